// File: doc/BRIEF.md
# First-Event Duty Cycle Terminator

This block produces the high-side gate pulse of a fixed-frequency synchronous buck stage. A free-running period counter, clocked at an integer multiple of the 200 kHz switching rate, starts one pulse at count zero of every period. Two sources race to end that pulse. One is a falling edge on the peak-current comparator output. The other is the end of a maximum-duty window set by a duty word from the power-point tracker. The first source to arrive ends the pulse, and any later event in that period is ignored.

With a low duty word, the window always closes before the current loop trips, so the tracker controls the converter. With a high duty word, the comparator normally ends the pulse. The duty word is copied into a shadow register only at a period boundary. Comparator edges that fall inside a short leading-edge blanking interval are discarded. A status output reports which source ended the most recent pulse.

The controller is a four-state machine. The states are IDLE (disabled), BLANK (gate high, comparator masked), ON (gate high, comparator armed) and OFF (gate low until the next period). The transitions are:
- T_HALT: any state goes to IDLE when enable is low.
- T_START: at a period boundary the machine goes to BLANK, or straight to ON when the blanking length is zero.
- T_SKIP: at a period boundary with a zero duty word the machine goes to OFF.
- T_UNBLANK: BLANK goes to ON when the blanking interval ends.
- T_TRIP: ON goes to OFF on a comparator event.
- T_LIMIT: BLANK or ON goes to OFF when the duty window closes.

Top module: `dct_first_event_term`

## Requirements
- R1: The period is CLK_HZ/SW_HZ clock cycles. After reset, the counter reads zero in the first cycle and wraps every period. The gate only rises in the cycle where the counter reads zero.
- R2: With no accepted comparator event, the gate is high for exactly D cycles, at counter values 0 to D-1, where D is the applied duty word. term_src then reads 2 (limit).
- R3: A comparator falling event is a cycle in which cmp_in is low after being high in the previous cycle. If it occurs while the gate is high at counter value F, with F ≥ BLANK_CYC and F < D, the gate is high for F+1 cycles and term_src reads 1 (comparator).
- R4: Only the first terminating source counts. After the gate falls, further comparator events in the same period change neither gate nor term_src. term_src changes only when the gate falls or at a period start.
- R5: Comparator events at counter values below BLANK_CYC are ignored.
- R6: If the comparator event and the closing of the duty window land on the same cycle, term_src reads 1 (comparator).
- R7: The applied duty word is the value of duty_max sampled in the last cycle of the previous period. Changes during a period have no effect on that period.
- R8: A duty word above PERIOD-1 is clamped to PERIOD-1, so the gate is low for at least one cycle each period.
- R9: A duty word of zero gives no pulse for that period, and term_src reads 2.
- R10: While en is low, the gate goes low in the cycle after en is first seen low and stays low, and term_src holds its value. A pulse cut short this way does not update term_src. After en returns high, pulses resume at the next period start.
- R11: During and just after reset, gate is 0 and term_src is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, an integer multiple of the switching frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces the gate off |
| cmp_in | input | 1 | Peak-current comparator output; a falling edge requests termination |
| duty_max | input | DUTY_W | Maximum duty in clock cycles, applied at the next period start |
| gate | output | 1 | High-side gate pulse |
| term_src | output | 2 | Source that ended the last pulse: 0 none, 1 comparator, 2 limit |

## Verification
The bench builds the block with CLK_HZ of 4 MHz and SW_HZ of 200 kHz, giving a 20-cycle period. It uses a blanking length of 3 and an 8-bit duty word. With these values, duty words above the clamp (R8) can be driven, and every counter position can be reached by a comparator edge: inside the blanking interval, on the duty boundary, and after the window has closed. The short period also allows many complete periods, including mid-pulse disables, in a short run. A scoreboard compares the full gate shape and the reported source period by period.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ON    = 2'd2,
        ST_OFF   = 2'd3
    } dct_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_CMP   = 2'd1,
        SRC_LIMIT = 2'd2
    } dct_src_e;

endpackage

// File: rtl/dct_period_ctr.sv
module dct_period_ctr #(
    parameter int PERIOD_CYC = 500,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R1

    AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R1

endmodule

// File: rtl/dct_duty_shadow.sv
module dct_duty_shadow #(
    parameter int DUTY_W   = 10,
    parameter int CNT_W    = 9,
    parameter int MAX_DUTY = 499
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_max,
    output logic [CNT_W-1:0]  duty_nxt,
    output logic [CNT_W-1:0]  duty_act
);
    localparam int XW = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;
    localparam logic [XW-1:0] CAP = XW'(MAX_DUTY);

    logic [XW-1:0] req_x;

    assign req_x    = XW'(duty_max);
    assign duty_nxt = (req_x > CAP) ? CNT_W'(CAP) : CNT_W'(req_x);

    always_ff @(posedge clk) begin
        if (!rst_n)    duty_act <= '0;
        else if (load) duty_act <= duty_nxt;
    end

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(duty_act)); // R7

    AST_DUTY_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (duty_act <= CNT_W'(MAX_DUTY))); // R8

endmodule

// File: rtl/dct_fall_det.sv
module dct_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic fall
);
    logic cmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_in;
    end

    assign fall = cmp_q & ~cmp_in;

endmodule

// File: rtl/dct_first_event_term.sv
module dct_first_event_term
    import dct_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int SW_HZ     = 200_000,
    parameter int BLANK_CYC = 20,
    parameter int DUTY_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cmp_in,
    input  logic [DUTY_W-1:0] duty_max,
    output logic              gate,
    output logic [1:0]        term_src
);
    localparam int PERIOD_CYC = CLK_HZ / SW_HZ;
    localparam int CNT_W      = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int MAX_DUTY   = PERIOD_CYC - 1;
    localparam logic [CNT_W:0] BLANK_END = (CNT_W + 1)'(BLANK_CYC);
    // Zero blanking skips the masked state entirely.
    localparam dct_state_e FIRST_ST = (BLANK_CYC == 0) ? ST_ON : ST_BLANK;

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] duty_nxt;
    logic [CNT_W-1:0] duty_act;
    logic             fall;
    logic [CNT_W:0]   cnt_nx;
    logic             lim_hit;
    logic             unblank;

    dct_state_e st_q, st_d;
    dct_src_e   src_q, src_d;

    dct_period_ctr #(
        .PERIOD_CYC (PERIOD_CYC),
        .CNT_W      (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    dct_duty_shadow #(
        .DUTY_W   (DUTY_W),
        .CNT_W    (CNT_W),
        .MAX_DUTY (MAX_DUTY)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wrap),
        .duty_max (duty_max),
        .duty_nxt (duty_nxt),
        .duty_act (duty_act)
    );

    dct_fall_det u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_in (cmp_in),
        .fall   (fall)
    );

    assign cnt_nx  = {1'b0, cnt} + 1'b1;
    assign lim_hit = (cnt_nx == {1'b0, duty_act});
    assign unblank = (cnt_nx == BLANK_END);

    // Next state and termination source.
    always_comb begin
        st_d  = st_q;
        src_d = src_q;
        if (!en) begin
            st_d = ST_IDLE;                          // T_HALT
        end else if (wrap) begin
            if (duty_nxt == '0) begin
                st_d  = ST_OFF;                      // T_SKIP
                src_d = SRC_LIMIT;
            end else begin
                st_d  = FIRST_ST;                    // T_START
            end
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_BLANK: begin
                    if (lim_hit) begin
                        st_d  = ST_OFF;              // T_LIMIT
                        src_d = SRC_LIMIT;
                    end else if (unblank) begin
                        st_d  = ST_ON;               // T_UNBLANK
                    end
                end
                ST_ON: begin
                    if (fall) begin
                        st_d  = ST_OFF;              // T_TRIP, wins a tie
                        src_d = SRC_CMP;
                    end else if (lim_hit) begin
                        st_d  = ST_OFF;              // T_LIMIT
                        src_d = SRC_LIMIT;
                    end
                end
                ST_OFF: st_d = ST_OFF;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            src_q <= SRC_NONE;
        end else begin
            st_q  <= st_d;
            src_q <= src_d;
        end
    end

    // Outputs.
    always_comb begin
        gate     = (st_q == ST_BLANK) || (st_q == ST_ON);
        term_src = src_q;
    end

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cnt == '0)); // R1

    AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> ({1'b0, cnt} < {1'b0, duty_act})); // R2

    AST_SRC_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_q) |-> ($fell(gate) || (cnt == '0))); // R4

    AST_BLANK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(en) && (src_q == SRC_CMP))
            |-> ({1'b0, $past(cnt)} >= BLANK_END)); // R5

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!gate && (term_src == 2'd0))); // R11

endmodule

// File: tb/tb_dct_first_event_term.sv
module tb_dct_first_event_term;
    localparam int CLK_HZ = 4_000_000;
    localparam int SW_HZ  = 200_000;
    localparam int P      = CLK_HZ / SW_HZ;
    localparam int BLANK  = 3;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          cmp_in = 1'b1;
    logic [DW-1:0] duty_max = '0;
    logic          gate;
    logic [1:0]    term_src;

    always #5 clk = ~clk;

    dct_first_event_term #(
        .CLK_HZ    (CLK_HZ),
        .SW_HZ     (SW_HZ),
        .BLANK_CYC (BLANK),
        .DUTY_W    (DW)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cmp_in   (cmp_in),
        .duty_max (duty_max),
        .gate     (gate),
        .term_src (term_src)
    );

    // Bench view of the period position (R1: wraps every P cycles).
    int tcnt;
    always @(posedge clk) begin
        if (!rst_n) tcnt <= 0;
        else        tcnt <= (tcnt == P - 1) ? 0 : tcnt + 1;
    end

    typedef struct {
        int    high;
        int    src;
        string req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int last_src = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: one full period, expected result pushed before it starts.
    task automatic run_period(input int d, input int f1, input int f2,
                              input bit en_v, input int dis_at,
                              input int mid_at, input int mid_d, input string req);
        exp_t e;
        int dc;
        int hi;
        int src;
        do @(negedge clk); while (tcnt != P - 1);
        #1;
        cmp_in   = 1'b1;
        duty_max = DW'(d);
        en       = en_v;
        dc = (d > P - 1) ? P - 1 : d;
        if (!en_v) begin
            hi = 0; src = last_src;
        end else if (dc == 0) begin
            hi = 0; src = 2;
        end else begin
            hi = dc; src = 2;
            if (f1 >= BLANK && f1 < dc) begin
                hi = f1 + 1; src = 1;
            end else if (f2 >= BLANK && f2 < dc) begin
                hi = f2 + 1; src = 1;
            end
            if (dis_at >= 0 && hi - 1 >= dis_at) begin
                hi = dis_at + 1; src = last_src;
            end
        end
        last_src = src;
        e.high = hi; e.src = src; e.req = req;
        sb.push_back(e);
        for (int k = 0; k < P - 1; k++) begin
            @(negedge clk);
            #1;
            cmp_in = !((k == f1) || (k == f2));
            if (k == dis_at) en = 1'b0;
            if (k == mid_at) duty_max = DW'(mid_d);
        end
    endtask

    // Monitor: compares the gate shape and source at the end of each period.
    initial begin
        exp_t cur;
        bit   active;
        int   bad;
        int   hi_seen;
        active = 1'b0; bad = 0; hi_seen = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tcnt == 0 && sb.size() > 0) begin
                    cur = sb.pop_front();
                    active = 1'b1; bad = 0; hi_seen = 0;
                end
                if (active) begin
                    if (gate) hi_seen++;
                    if (gate !== (tcnt < cur.high)) bad++;
                    if (tcnt == P - 1) begin
                        check(bad == 0, cur.req, "gate high cycles", hi_seen, cur.high);
                        check(int'(term_src) == cur.src, cur.req, "term_src",
                              int'(term_src), cur.src);
                        active = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1: watchdog expired actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(gate == 1'b0, "R11", "gate in reset", int'(gate), 0);
        check(term_src == 2'd0, "R11", "term_src in reset", int'(term_src), 0);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        check(gate == 1'b0, "R11", "gate after reset", int'(gate), 0);
        check(term_src == 2'd0, "R11", "term_src after reset", int'(term_src), 0);

        //          d    f1  f2  en  dis  mid  mid_d
        run_period(8,   -1, -1, 1,  -1,  -1,  0,  "R1 R2 limit");
        run_period(12,  6,  -1, 1,  -1,  -1,  0,  "R3 comparator");
        run_period(12,  1,  -1, 1,  -1,  -1,  0,  "R5 blanked edge");
        run_period(12,  1,  5,  1,  -1,  -1,  0,  "R5 R4 blanked then live");
        run_period(12,  4,  9,  1,  -1,  -1,  0,  "R4 second edge ignored");
        run_period(5,   8,  -1, 1,  -1,  -1,  0,  "R4 edge after limit");
        run_period(10,  9,  -1, 1,  -1,  -1,  0,  "R6 tie");
        run_period(0,   -1, -1, 1,  -1,  -1,  0,  "R9 zero duty");
        run_period(200, -1, -1, 1,  -1,  -1,  0,  "R8 clamp");
        run_period(10,  -1, -1, 1,  -1,  2,   3,  "R7 mid-period write");
        run_period(3,   -1, -1, 1,  -1,  -1,  0,  "R7 new word applied");
        run_period(10,  6,  -1, 1,  -1,  -1,  0,  "R3 before disable");
        run_period(10,  6,  -1, 0,  -1,  -1,  0,  "R10 disabled");
        run_period(10,  6,  -1, 1,  -1,  -1,  0,  "R10 resumed");
        run_period(15,  -1, -1, 1,  4,   -1,  0,  "R10 cut mid-pulse");
        run_period(2,   -1, -1, 1,  -1,  -1,  0,  "R2 R5 limit in blanking");
        run_period(1,   0,  -1, 1,  -1,  -1,  0,  "R2 one-cycle pulse");

        repeat (2 * P + 2) @(negedge clk);
        check(sb.size() == 0, "R1", "scoreboard left over", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule